// File: doc/BRIEF.md
# Serial Scan Register Display Link

This block carries a 16-bit processor word, data or address, to a remote bank of 16 indicator bits over one serial wire. A free-running 8-bit counter sets the pace. The counter's low nibble, inverted, picks one bit of the parallel word and puts it on the serial line. A 16-bit display register at the far end takes that bit in on the falling clock edge, so the line has half a cycle to settle.

Each 256-state counter cycle has two phases. The scan phase covers the 16 states in which the upper counter bits are all zero. During it, the display register shifts in one bit per state. The hold phase covers the other 240 states. During it, the register keeps its contents, so the indicators show a steady value. The source word normally changes slowly compared with one cycle, so the display tracks it without flicker.

A run-enable input plays the part of a power-good signal: while it is low, the counter and the display register both stand still. A synchronous active-high reset clears the counter and the display register. The reset exists for simulation and is not part of free-running operation.

Top module: `scan_display_link`

## Requirements
- R1: While run_en is high, the internal 8-bit count advances by one on every rising clock edge and wraps from 255 to 0. As a result, a new scan phase starts exactly every 256 cycles.
- R2: While run_en is low, the count does not change and the display register does not change. Both continue from where they stopped once run_en returns high.
- R3: scan_sel is the bitwise inverse of the count's low nibble. Count state 0 gives scan_sel 15, and each following state lowers scan_sel by one, down to 0 at state 15.
- R4: ser_bit always equals bit number scan_sel of par_word.
- R5: shift_en is high exactly when the four upper count bits are zero (states 0 to 15). It is therefore high for 16 consecutive cycles of every 256.
- R6: On each falling clock edge where shift_en and run_en are both high, the display register moves every bit one place toward its MSB and loads ser_bit into bit 0. After n scan states from a cleared register, disp equals par_word shifted right by 16-n.
- R7: After a complete scan with a stable par_word, disp equals par_word bit for bit, with par_word bit 15 in disp bit 15. disp then holds that value through the hold phase even if par_word changes.
- R8: With rst high at a rising and a falling edge, the count becomes 0 and disp becomes 0. This shows at the ports as scan_sel = 15, shift_en = 1 and disp = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The counter uses the rising edge and the display register uses the falling edge. |
| rst | input | 1 | Synchronous active-high reset of the counter and the display register |
| run_en | input | 1 | Power-good: counting and shifting take place only while this is high |
| par_word | input | 16 | Parallel word to be carried to the display |
| ser_bit | output | 1 | Serial line: the currently selected bit of par_word |
| shift_en | output | 1 | High during the scan phase (count states 0 to 15) |
| scan_sel | output | 4 | Multiplexer select, the inverted low nibble of the count |
| disp | output | 16 | Display register contents driving the indicators |

## Verification
Two things can happen in the same cycle: the run enable can drop in the middle of the scan phase, and a falling-edge shift can be due. The bench provokes this by lowering run_en a few states into a scan. It then checks that scan_sel and disp stay frozen for many cycles, and that the scan finished after resuming still yields the full word. A second coincidence is a change of par_word in the cycle right after the last shift. The bench judges this by requiring disp to keep the old word throughout the hold phase.

// File: rtl/scan_link_pkg.sv
package scan_link_pkg;
    localparam int unsigned DEF_WORD_W = 16;
    localparam int unsigned DEF_CNT_W  = 8;

    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_SCAN = 1'b1
    } link_phase_e;
endpackage

// File: rtl/scan_pace_counter.sv
module scan_pace_counter
    import scan_link_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    output logic [CNT_W-1:0] count,
    output link_phase_e      phase
);
    localparam int unsigned HI_W = CNT_W - SEL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pace_state_t;

    pace_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (run_en) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign phase = (st_q.cnt[CNT_W-1 -: HI_W] == '0) ? PH_SCAN : PH_HOLD;
endmodule

// File: rtl/scan_bit_mux.sv
module scan_bit_mux #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  cnt_lo,
    input  logic [WORD_W-1:0] word,
    output logic [SEL_W-1:0]  sel,
    output logic              bit_out
);
    logic [WORD_W-1:0] hit;

    assign sel = ~cnt_lo;

    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_lane
        assign hit[gi] = word[gi] & (sel == SEL_W'(gi));
    end

    assign bit_out = |hit;
endmodule

// File: rtl/display_shifter.sv
module display_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              ser_in,
    output logic [WORD_W-1:0] value
);
    typedef struct packed {
        logic [WORD_W-1:0] reg_bits;
    } shifter_state_t;

    shifter_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (rst) begin
            sh_d.reg_bits = '0;
        end else if (shift) begin
            sh_d.reg_bits = {sh_q.reg_bits[WORD_W-2:0], ser_in};
        end
    end

    // falling edge: the serial bit has had half a cycle to settle
    always_ff @(negedge clk) begin
        sh_q <= sh_d;
    end

    assign value = sh_q.reg_bits;
endmodule

// File: rtl/scan_display_link.sv
module scan_display_link
    import scan_link_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_en,
    input  logic [WORD_W-1:0]        par_word,
    output logic                     ser_bit,
    output logic                     shift_en,
    output logic [$clog2(WORD_W)-1:0] scan_sel,
    output logic [WORD_W-1:0]        disp
);
    localparam int unsigned SEL_W = $clog2(WORD_W);

    logic [CNT_W-1:0] count;
    link_phase_e      phase;

    scan_pace_counter #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_pace (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .count  (count),
        .phase  (phase)
    );

    scan_bit_mux #(
        .WORD_W (WORD_W),
        .SEL_W  (SEL_W)
    ) u_mux (
        .cnt_lo  (count[SEL_W-1:0]),
        .word    (par_word),
        .sel     (scan_sel),
        .bit_out (ser_bit)
    );

    assign shift_en = (phase == PH_SCAN);

    display_shifter #(
        .WORD_W (WORD_W)
    ) u_disp (
        .clk    (clk),
        .rst    (rst),
        .shift  (shift_en & run_en),
        .ser_in (ser_bit),
        .value  (disp)
    );
endmodule

// File: rtl/scan_display_link_chk.sv
module scan_display_link_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      run_en,
    input logic [CNT_W-1:0]          count,
    input logic                      shift_en,
    input logic [$clog2(WORD_W)-1:0] scan_sel,
    input logic [WORD_W-1:0]         disp
);
    // R1: one step per enabled rising edge, wrapping
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        run_en |=> count == CNT_W'($past(count) + CNT_W'(1)));

    // R2: frozen counter while not running
    p_count_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(count));

    // R2: no shift at the falling edge of a stopped cycle
    p_disp_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> $stable(disp));

    // R3: a scan begins on the highest select
    p_scan_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_en) |-> (scan_sel == '1));

    // R5: the scan ends right after the lowest select
    p_scan_end_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_en) |-> ($past(scan_sel) == '0));

    // R6: one-place move toward the MSB on an enabled scan cycle
    p_shift_move_r6: assert property (@(posedge clk) disable iff (rst)
        (shift_en && run_en) |-> (disp[WORD_W-1:1] == $past(disp[WORD_W-2:0])));

    // R7: display is static through the hold phase
    p_hold_static_r7: assert property (@(posedge clk) disable iff (rst)
        !shift_en |-> $stable(disp));
endmodule

bind scan_display_link scan_display_link_chk #(
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .count    (count),
    .shift_en (shift_en),
    .scan_sel (scan_sel),
    .disp     (disp)
);

// File: tb/scan_display_link_test.sv
module scan_display_link_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic [15:0] par_word = '0;
    logic        ser_bit;
    logic        shift_en;
    logic [3:0]  scan_sel;
    logic [15:0] disp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scan_display_link uut (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .par_word (par_word),
        .ser_bit  (ser_bit),
        .shift_en (shift_en),
        .scan_sel (scan_sel),
        .disp     (disp)
    );

    // inputs change 2 ns after a rising edge; reads follow 1 ns later
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] w);
        tick();
        rst = 1'b1;
        run_en = 1'b1;
        par_word = w;
        tick();
        tick();
        rst = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        tick();
        rst = 1'b1;
        tick();
        tick();
        #1;
        check("R8", "scan_sel after reset", 32'(scan_sel), 32'hF);
        check("R8", "shift_en after reset", 32'(shift_en), 32'h1);
        check("R8", "disp after reset", 32'(disp), 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_scan_sequence(input logic [15:0] w);
        do_reset(w);
        for (int n = 1; n <= 16; n++) begin
            tick();
            #1;
            check("R3", "scan_sel step", 32'(scan_sel), 32'((15 - n) & 15));
            check("R4", "ser_bit", 32'(ser_bit), 32'(w[(15 - n) & 15]));
            check("R6", "partial disp", 32'(disp), 32'(w >> (16 - n)));
            check("R5", "shift_en in scan", 32'(shift_en), 32'(n < 16));
        end
        check("R7", "full scan result", 32'(disp), 32'(w));
    endtask

    task automatic t_freeze(input logic [15:0] w);
        logic [3:0]  sel_hold;
        logic [15:0] disp_hold;
        do_reset(w);
        repeat (5) tick();
        run_en = 1'b0;
        #1;
        sel_hold = scan_sel;
        disp_hold = disp;
        repeat (12) tick();
        #1;
        check("R2", "scan_sel frozen", 32'(scan_sel), 32'(sel_hold));
        check("R2", "disp frozen", 32'(disp), 32'(disp_hold));
        check("R2", "shift_en frozen", 32'(shift_en), 32'h1);
        run_en = 1'b1;
        repeat (11) tick();
        #1;
        check("R2", "scan completes after resume", 32'(disp), 32'(w));
        check("R5", "hold after resumed scan", 32'(shift_en), 32'h0);
    endtask

    task automatic t_period();
        int highs;
        int guard;
        guard = 0;
        // move to the first cycle of a scan phase: shift_en low, then high
        while (shift_en && guard < 300) begin tick(); #1; guard++; end
        while (!shift_en && guard < 600) begin tick(); #1; guard++; end
        check("R1", "scan start located", 32'(guard < 600), 32'h1);
        check("R3", "scan starts at top select", 32'(scan_sel), 32'hF);
        highs = 0;
        for (int k = 0; k < 256; k++) begin
            if (shift_en) highs++;
            tick();
            #1;
        end
        check("R5", "scan states per cycle", 32'(highs), 32'd16);
        check("R1", "wrap after 256 states", 32'(scan_sel), 32'hF);
        check("R1", "new scan after 256 states", 32'(shift_en), 32'h1);
    endtask

    task automatic t_capture(input logic [15:0] w);
        int guard;
        guard = 0;
        tick();
        par_word = w;
        #1;
        // wait for a whole scan with w stable: rise, then fall
        while (shift_en && guard < 300) begin tick(); #1; guard++; end
        while (!shift_en && guard < 600) begin tick(); #1; guard++; end
        while (shift_en && guard < 700) begin tick(); #1; guard++; end
        check("R7", "captured word", 32'(disp), 32'(w));
        par_word = ~w;
        repeat (30) tick();
        #1;
        check("R7", "hold ignores new word", 32'(disp), 32'(w));
        check("R4", "ser_bit follows new word", 32'(ser_bit), 32'(par_word[scan_sel]));
    endtask

    initial begin
        t_reset();
        t_scan_sequence(16'hA5C3);
        t_scan_sequence(16'h8001);
        t_freeze(16'h3C96);
        t_period();
        for (int r = 0; r < 4; r++) begin
            t_capture(16'($urandom));
        end
        t_capture(16'hFFFF);
        t_capture(16'h0000);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule